// File: doc/BRIEF.md
# MESIF Line State Controller

This block keeps the coherence state of every line in one small cache under a five-state protocol: Modified, Exclusive, Shared, Forward and Invalid. The core side issues reads, writes and flushes. The interconnect side issues snoop reads and snoop writes that come from peer caches. For each accepted event the block looks up the line, updates its state and tag, and reports one response. The response carries the new state, whether the access hit, whether this cache must supply the line's data, whether peers must be told to invalidate their copies, and whether dirty data must be written back.

The Forward state gives a line that is shared by several caches exactly one clean holder that answers read snoops. The most recent reader always takes this role. A core read that misses while a peer holds the line ends in Forward. A snoop read that finds the line in Forward, Exclusive or Modified supplies the data and drops the local copy to Shared. Tags and states are kept in a direct-mapped array indexed by the low address bits. Data storage and bus transport sit outside the block.

Top module: `mesif_line_ctrl`

## Requirements
- R1: States are encoded on 3 bits as Invalid=0, Shared=1, Exclusive=2, Forward=3, Modified=4. Reset leaves every line Invalid and no response is pending.
- R2: A core read (core_op=0) that misses ends in Exclusive when core_peer_has is 0 and in Forward when it is 1, and reports hit=0.
- R3: A core read that hits a line in any valid state leaves the state unchanged and reports hit=1, with no invalidate request and no writeback.
- R4: A core write (core_op=1) always ends in Modified. It raises the invalidate request unless it hit a line already held in Exclusive or Modified.
- R5: A snoop read (snp_op=0) that hits a Modified, Exclusive or Forward line supplies the data and moves the line to Shared, with a writeback only from Modified. A Shared line stays Shared and supplies nothing. A snoop miss reports Invalid and changes nothing.
- R6: A snoop write (snp_op=1) that hits any valid line moves it to Invalid, with no data supply, and raises writeback exactly when the line was Modified.
- R7: A core flush (core_op=2 or 3) that hits moves the line to Invalid, with writeback exactly when it was Modified. A flush that misses reports Invalid and leaves the array unchanged.
- R8: A core read or write that misses on an index holding a different-tag Modified line raises writeback, and the new tag replaces the old one. After that, an access to the old tag misses.
- R9: snp_ready is always 1 and core_ready is the inverse of snp_valid, so a snoop wins when both requests arrive in the same cycle. The array changes only for a granted request.
- R10: Each granted request produces exactly one response with rsp_valid high in the following cycle. rsp_from_snoop gives the source. Data supply appears only on snoop responses, and the invalidate request appears only on core responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_valid | input | 1 | Core request present |
| core_ready | output | 1 | Core request accepted this cycle |
| core_op | input | 2 | 0 read, 1 write, 2 or 3 flush |
| core_addr | input | ADDR_W | Line address: tag above, index in low IDX_W bits |
| core_peer_has | input | 1 | A peer cache holds the line (used on read miss) |
| snp_valid | input | 1 | Snoop request present |
| snp_ready | output | 1 | Snoop request accepted (always 1) |
| snp_op | input | 1 | 0 snoop read, 1 snoop write |
| snp_addr | input | ADDR_W | Snooped line address |
| rsp_valid | output | 1 | Response for the request granted last cycle |
| rsp_from_snoop | output | 1 | Response belongs to a snoop |
| rsp_hit | output | 1 | Tag matched a valid line |
| rsp_state | output | 3 | Line state after the event |
| rsp_supply | output | 1 | This cache must supply the line's data |
| rsp_inv_req | output | 1 | Peers must invalidate their copies |
| rsp_wb | output | 1 | Dirty data must be written back |

## Verification
On every cycle the assertions check the arbitration rule. They also check that a response follows each grant and only a grant, that data supply comes only from snoops and only together with a Shared result, that invalidate requests come only from core writes ending in Modified, and that snoops never leave a line Exclusive, Forward or Modified. The sequences that depend on history need the bench's directed scenarios: a reader landing in Forward while the earlier holder drops to Shared, writes that skip the invalidate from Exclusive, flushes and snoop writes followed by re-reads that prove the line is gone, and victim replacement of a dirty line.

// File: rtl/mesif_pkg.sv
package mesif_pkg;

  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_F = 3'd3,
    ST_M = 3'd4
  } mstate_t;

  typedef struct packed {
    mstate_t nxt;
    logic    hit;
    logic    supply;
    logic    inv;
    logic    wb;
    logic    wr_en;
  } verdict_t;

  function automatic logic holds(mstate_t s);
    return s != ST_I;
  endfunction

  // Core side: op 0 read, 1 write, 2/3 flush (R2, R3, R4, R7, R8)
  function automatic verdict_t core_event(logic [1:0] op, mstate_t cur,
                                          logic tag_eq, logic peer_has);
    verdict_t v;
    logic     hit;
    logic     dirty_victim;
    hit          = tag_eq && holds(cur);
    dirty_victim = !tag_eq && (cur == ST_M);
    v        = '0;
    v.hit    = hit;
    if (op[1]) begin
      v.nxt   = ST_I;
      v.wr_en = hit;
      v.wb    = hit && (cur == ST_M);
    end else if (op[0]) begin
      v.nxt   = ST_M;
      v.wr_en = 1'b1;
      v.inv   = !(hit && (cur == ST_E || cur == ST_M));
      v.wb    = dirty_victim;
    end else if (hit) begin
      v.nxt   = cur;
      v.wr_en = 1'b0;
    end else begin
      v.nxt   = peer_has ? ST_F : ST_E;
      v.wr_en = 1'b1;
      v.wb    = dirty_victim;
    end
    return v;
  endfunction

  // Interconnect side: op 0 snoop read, 1 snoop write (R5, R6)
  function automatic verdict_t snoop_event(logic op, mstate_t cur, logic tag_eq);
    verdict_t v;
    logic     hit;
    hit   = tag_eq && holds(cur);
    v     = '0;
    v.hit = hit;
    v.nxt = ST_I;
    if (hit) begin
      if (op) begin
        v.nxt   = ST_I;
        v.wr_en = 1'b1;
        v.wb    = (cur == ST_M);
      end else begin
        v.nxt    = ST_S;
        v.supply = (cur == ST_M) || (cur == ST_E) || (cur == ST_F);
        v.wb     = (cur == ST_M);
        v.wr_en  = (cur != ST_S);
      end
    end
    return v;
  endfunction

endpackage

// File: rtl/mesif_arbiter.sv
module mesif_arbiter (
  input  logic core_valid,
  input  logic snp_valid,
  output logic core_ready,
  output logic snp_ready,
  output logic core_go,
  output logic snp_go
);
  // Snoops are never back-pressured and take priority (R9)
  assign snp_ready  = 1'b1;
  assign core_ready = !snp_valid;
  assign snp_go     = snp_valid;
  assign core_go    = core_valid && !snp_valid;
endmodule

// File: rtl/mesif_line_array.sv
module mesif_line_array
  import mesif_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output mstate_t          rd_state,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  mstate_t          wr_state,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int LINES = 1 << IDX_W;

  mstate_t          st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g]  <= ST_I;
        tag_q[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        st_q[g]  <= wr_state;
        tag_q[g] <= wr_tag;
      end
    end
  end

  assign rd_state = st_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/mesif_decide.sv
module mesif_decide
  import mesif_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             sel_snoop,
  input  logic [1:0]       core_op,
  input  logic             core_peer_has,
  input  logic             snp_op,
  input  mstate_t          cur_state,
  input  logic [TAG_W-1:0] cur_tag,
  input  logic [TAG_W-1:0] req_tag,
  output verdict_t         verdict
);
  logic tag_eq;
  assign tag_eq = (cur_tag == req_tag);

  always_comb begin
    if (sel_snoop) verdict = snoop_event(snp_op, cur_state, tag_eq);
    else           verdict = core_event(core_op, cur_state, tag_eq, core_peer_has);
  end
endmodule

// File: rtl/mesif_line_ctrl.sv
module mesif_line_ctrl
  import mesif_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 6,
  parameter int ADDR_W = IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_valid,
  output logic              core_ready,
  input  logic [1:0]        core_op,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              core_peer_has,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic              snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              rsp_valid,
  output logic              rsp_from_snoop,
  output logic              rsp_hit,
  output logic [2:0]        rsp_state,
  output logic              rsp_supply,
  output logic              rsp_inv_req,
  output logic              rsp_wb
);
  // Named internal events, visible to the bound checker
  logic              ev_core_go;
  logic              ev_snp_go;
  logic              ev_any_go;
  logic              ev_wr_en;
  logic [ADDR_W-1:0] sel_addr;
  logic [IDX_W-1:0]  sel_idx;
  logic [TAG_W-1:0]  sel_tag;
  mstate_t           cur_state;
  logic [TAG_W-1:0]  cur_tag;
  verdict_t          verdict;

  mesif_arbiter u_arb (
    .core_valid (core_valid),
    .snp_valid  (snp_valid),
    .core_ready (core_ready),
    .snp_ready  (snp_ready),
    .core_go    (ev_core_go),
    .snp_go     (ev_snp_go)
  );

  assign ev_any_go = ev_core_go || ev_snp_go;
  assign sel_addr  = ev_snp_go ? snp_addr : core_addr;
  assign sel_idx   = sel_addr[IDX_W-1:0];
  assign sel_tag   = sel_addr[ADDR_W-1:IDX_W];

  mesif_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (sel_idx),
    .rd_state (cur_state),
    .rd_tag   (cur_tag),
    .wr_en    (ev_wr_en),
    .wr_idx   (sel_idx),
    .wr_state (verdict.nxt),
    .wr_tag   (sel_tag)
  );

  mesif_decide #(.TAG_W(TAG_W)) u_decide (
    .sel_snoop     (ev_snp_go),
    .core_op       (core_op),
    .core_peer_has (core_peer_has),
    .snp_op        (snp_op),
    .cur_state     (cur_state),
    .cur_tag       (cur_tag),
    .req_tag       (sel_tag),
    .verdict       (verdict)
  );

  assign ev_wr_en = ev_any_go && verdict.wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_from_snoop <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_state      <= 3'd0;
      rsp_supply     <= 1'b0;
      rsp_inv_req    <= 1'b0;
      rsp_wb         <= 1'b0;
    end else begin
      rsp_valid      <= ev_any_go;
      rsp_from_snoop <= ev_snp_go;
      rsp_hit        <= ev_any_go && verdict.hit;
      rsp_state      <= ev_any_go ? verdict.nxt : ST_I;
      rsp_supply     <= ev_any_go && verdict.supply;
      rsp_inv_req    <= ev_any_go && verdict.inv;
      rsp_wb         <= ev_any_go && verdict.wb;
    end
  end
endmodule

// File: rtl/mesif_line_ctrl_chk.sv
module mesif_line_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       core_valid,
  input logic       core_ready,
  input logic       snp_valid,
  input logic       snp_ready,
  input logic       ev_core_go,
  input logic       ev_snp_go,
  input logic       ev_wr_en,
  input logic       rsp_valid,
  input logic       rsp_from_snoop,
  input logic [2:0] rsp_state,
  input logic       rsp_supply,
  input logic       rsp_inv_req
);
  import mesif_pkg::*;

  assert_snoop_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!core_ready && snp_ready));

  assert_write_needs_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_en |-> ((ev_core_go && core_valid) || (ev_snp_go && snp_valid)));

  assert_resp_follows_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_core_go || ev_snp_go) |=> rsp_valid);

  assert_no_resp_without_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_core_go || ev_snp_go) |=> !rsp_valid);

  assert_resp_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_snp_go |=> rsp_from_snoop);

  assert_supply_from_snoop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_supply) |-> (rsp_from_snoop && rsp_state == ST_S));

  assert_inv_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_inv_req) |-> (!rsp_from_snoop && rsp_state == ST_M));

  assert_snoop_downgrades_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_from_snoop) |-> (rsp_state == ST_I || rsp_state == ST_S));

  assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_state <= 3'd4);
endmodule

bind mesif_line_ctrl mesif_line_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .core_valid     (core_valid),
  .core_ready     (core_ready),
  .snp_valid      (snp_valid),
  .snp_ready      (snp_ready),
  .ev_core_go     (ev_core_go),
  .ev_snp_go      (ev_snp_go),
  .ev_wr_en       (ev_wr_en),
  .rsp_valid      (rsp_valid),
  .rsp_from_snoop (rsp_from_snoop),
  .rsp_state      (rsp_state),
  .rsp_supply     (rsp_supply),
  .rsp_inv_req    (rsp_inv_req)
);

// File: tb/tb_mesif_line_ctrl.sv
`timescale 1ns/1ps
module tb_mesif_line_ctrl;
  localparam int IDX_W  = 3;
  localparam int TAG_W  = 6;
  localparam int ADDR_W = IDX_W + TAG_W;
  // state codes per R1
  localparam logic [2:0] I = 3'd0, S = 3'd1, E = 3'd2, F = 3'd3, M = 3'd4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              core_valid = 1'b0;
  logic              core_ready;
  logic [1:0]        core_op = 2'd0;
  logic [ADDR_W-1:0] core_addr = '0;
  logic              core_peer_has = 1'b0;
  logic              snp_valid = 1'b0;
  logic              snp_ready;
  logic              snp_op = 1'b0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic              rsp_valid, rsp_from_snoop, rsp_hit, rsp_supply, rsp_inv_req, rsp_wb;
  logic [2:0]        rsp_state;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mesif_line_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .core_valid(core_valid), .core_ready(core_ready), .core_op(core_op),
    .core_addr(core_addr), .core_peer_has(core_peer_has),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_op(snp_op), .snp_addr(snp_addr),
    .rsp_valid(rsp_valid), .rsp_from_snoop(rsp_from_snoop), .rsp_hit(rsp_hit),
    .rsp_state(rsp_state), .rsp_supply(rsp_supply), .rsp_inv_req(rsp_inv_req),
    .rsp_wb(rsp_wb)
  );

  function automatic logic [ADDR_W-1:0] mk(int tag, int idx);
    return {TAG_W'(tag), IDX_W'(idx)};
  endfunction

  task automatic check_bits(string req, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Compares {valid, from_snoop, hit, state, supply, inv, wb}
  task automatic expect_rsp(string req, logic src, logic hit, logic [2:0] st,
                            logic sup, logic inv, logic wb);
    check_bits(req, "response",
      16'({rsp_valid, rsp_from_snoop, rsp_hit, rsp_state, rsp_supply, rsp_inv_req, rsp_wb}),
      16'({1'b1, src, hit, st, sup, inv, wb}));
  endtask

  task automatic core_req(logic [1:0] op, logic [ADDR_W-1:0] a, logic peer);
    @(negedge clk);
    core_valid = 1'b1; core_op = op; core_addr = a; core_peer_has = peer;
    @(negedge clk);
    core_valid = 1'b0;
  endtask

  task automatic snp_req(logic op, logic [ADDR_W-1:0] a);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic t_reset();
    check_bits("R1", "rsp_valid after reset", 16'(rsp_valid), 16'd0);
    check_bits("R9", "ready pair idle", 16'({core_ready, snp_ready}), 16'b11);
  endtask

  task automatic t_read_miss_R2();
    core_req(2'd0, mk(1, 0), 1'b0); expect_rsp("R2", 0, 0, E, 0, 0, 0);
    core_req(2'd0, mk(1, 1), 1'b1); expect_rsp("R2", 0, 0, F, 0, 0, 0);
  endtask

  task automatic t_read_hit_R3();
    core_req(2'd0, mk(1, 0), 1'b1); expect_rsp("R3", 0, 1, E, 0, 0, 0);
    core_req(2'd0, mk(1, 1), 1'b0); expect_rsp("R3", 0, 1, F, 0, 0, 0);
  endtask

  task automatic t_snoop_read_R5();
    snp_req(1'b0, mk(1, 0));        expect_rsp("R5", 1, 1, S, 1, 0, 0);
    snp_req(1'b0, mk(1, 0));        expect_rsp("R5", 1, 1, S, 0, 0, 0);
    core_req(2'd0, mk(1, 0), 1'b0); expect_rsp("R3", 0, 1, S, 0, 0, 0);
    snp_req(1'b0, mk(1, 1));        expect_rsp("R5", 1, 1, S, 1, 0, 0);
    snp_req(1'b0, mk(3, 5));        expect_rsp("R5", 1, 0, I, 0, 0, 0);
  endtask

  task automatic t_write_R4();
    core_req(2'd1, mk(1, 1), 1'b0); expect_rsp("R4", 0, 1, M, 0, 1, 0);
    core_req(2'd1, mk(1, 1), 1'b0); expect_rsp("R4", 0, 1, M, 0, 0, 0);
    core_req(2'd0, mk(1, 1), 1'b0); expect_rsp("R3", 0, 1, M, 0, 0, 0);
    snp_req(1'b0, mk(1, 1));        expect_rsp("R5", 1, 1, S, 1, 0, 1);
    core_req(2'd1, mk(2, 2), 1'b0); expect_rsp("R4", 0, 0, M, 0, 1, 0);
    core_req(2'd0, mk(1, 3), 1'b0); expect_rsp("R2", 0, 0, E, 0, 0, 0);
    core_req(2'd1, mk(1, 3), 1'b1); expect_rsp("R4", 0, 1, M, 0, 0, 0);
  endtask

  task automatic t_snoop_write_R6();
    snp_req(1'b1, mk(1, 3));        expect_rsp("R6", 1, 1, I, 0, 0, 1);
    core_req(2'd0, mk(1, 3), 1'b0); expect_rsp("R6", 0, 0, E, 0, 0, 0);
    snp_req(1'b1, mk(1, 0));        expect_rsp("R6", 1, 1, I, 0, 0, 0);
    core_req(2'd0, mk(1, 0), 1'b1); expect_rsp("R6", 0, 0, F, 0, 0, 0);
  endtask

  task automatic t_flush_R7();
    core_req(2'd2, mk(2, 2), 1'b0); expect_rsp("R7", 0, 1, I, 0, 0, 1);
    core_req(2'd2, mk(2, 2), 1'b0); expect_rsp("R7", 0, 0, I, 0, 0, 0);
    core_req(2'd0, mk(2, 2), 1'b0); expect_rsp("R7", 0, 0, E, 0, 0, 0);
    core_req(2'd3, mk(2, 2), 1'b0); expect_rsp("R7", 0, 1, I, 0, 0, 0);
  endtask

  task automatic t_victim_R8();
    core_req(2'd1, mk(1, 4), 1'b0); expect_rsp("R8", 0, 0, M, 0, 1, 0);
    core_req(2'd0, mk(2, 4), 1'b0); expect_rsp("R8", 0, 0, E, 0, 0, 1);
    core_req(2'd0, mk(1, 4), 1'b0); expect_rsp("R8", 0, 0, E, 0, 0, 0);
    snp_req(1'b0, mk(2, 4));        expect_rsp("R8", 1, 0, I, 0, 0, 0);
  endtask

  task automatic t_arbitration_R9();
    @(negedge clk);
    core_valid = 1'b1; core_op = 2'd0; core_addr = mk(1, 6); core_peer_has = 1'b0;
    snp_valid  = 1'b1; snp_op = 1'b0;  snp_addr = mk(1, 6);
    #1;
    check_bits("R9", "core_ready under snoop", 16'(core_ready), 16'd0);
    @(negedge clk);
    snp_valid = 1'b0;
    expect_rsp("R9", 1, 0, I, 0, 0, 0);
    @(negedge clk);
    core_valid = 1'b0;
    expect_rsp("R10", 0, 0, E, 0, 0, 0);
    @(negedge clk);
    check_bits("R10", "no response when idle", 16'(rsp_valid), 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_miss_R2();
    t_read_hit_R3();
    t_snoop_read_R5();
    t_write_R4();
    t_snoop_write_R6();
    t_flush_R7();
    t_victim_R8();
    t_arbitration_R9();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule